// File: doc/BRIEF.md
# Repeated String Transfer Engine

This block executes one string primitive per start pulse. The five primitives are copy, compare, scan, load and store, each on bytes or on 16-bit words. It can run a primitive once or under one of three repeat forms. When a start is accepted, the engine latches two segment bases, a source offset, a destination offset, an element count, an accumulator, a width select and a direction flag. It then walks the strings, computing each 20-bit address as segment times sixteen plus offset. It reaches memory through a single valid/ready port that returns read data in the same cycle as ready.

The caller reads the final offsets, count, accumulator and equality (zero) flag from the outputs once `done` pulses. The offsets and count advance as the elements are processed. The zero flag persists across runs, and only compare-type primitives change it. Its reset value is 0.

Top module: `string_xfer_engine`

## Requirements
- R1: The source element is read at srcSeg*16 + srcOff and the destination element is read or written at dstSeg*16 + dstOff, both as 20-bit addresses. A word access covers the address and the next byte, with the low byte at the lower address and data on memRdata/memWdata[15:0]. A byte uses bits [7:0].
- R2: After each element, each offset the primitive uses moves by 1 (wordMode=0) or 2 (wordMode=1). It moves up when dirFlag=0 and down when dirFlag=1, wrapping modulo 2^16.
- R3: With repSel=1 (unconditional repeat), the count is tested before each element. If it is nonzero it is decremented and one element is processed. If it is zero the run ends with no memory access.
- R4: With repSel=2 a compare or scan also ends after any element that leaves the zero flag at 0. With repSel=3 it also ends after any element that leaves the zero flag at 1. For copy, load and store, codes 2 and 3 behave like code 1.
- R5: With repSel=0 exactly one element is processed and the count output keeps its starting value.
- R6: Copy, load and store leave the zero flag unchanged. Compare and scan set it to 1 exactly when the two operands are equal in the active width, and to 0 otherwise. It is 0 after reset.
- R7: Primitive codes on opSel are as follows. 0 copies source to destination and advances both offsets. 1 compares source with destination and advances both. 2 compares the accumulator with the destination and advances only dstOff. 3 reads the source into the accumulator (a byte replaces only bits [7:0]) and advances only srcOff. 4 writes the accumulator to the destination and advances only dstOff. Codes 5 to 7 act as 0. Only codes 0 and 4 ever write memory.
- R8: busy is 0 after reset and rises in the cycle after an accepted start. It stays high until termination. done is then high for exactly one cycle with busy low. A start seen while busy or done is high is ignored.
- R9: While memReq is high and memReady is low, memReq, memAddr, memWrite and memWdata stay stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run with the configuration below |
| opSel | input | 3 | Primitive code |
| repSel | input | 2 | Repeat form: 0 none, 1 unconditional, 2 while equal, 3 while unequal |
| wordMode | input | 1 | 1 selects 16-bit elements |
| dirFlag | input | 1 | 1 walks downward |
| srcSegIn | input | 16 | Source segment base |
| dstSegIn | input | 16 | Destination segment base |
| srcOffIn | input | 16 | Starting source offset |
| dstOffIn | input | 16 | Starting destination offset |
| countIn | input | 16 | Starting element count |
| accIn | input | 16 | Starting accumulator |
| memReq | output | 1 | Memory request valid |
| memWrite | output | 1 | Request is a write |
| memWide | output | 1 | Request covers two bytes |
| memAddr | output | 20 | Byte address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memReady |
| memReady | input | 1 | Request accepted this cycle |
| srcOff | output | 16 | Current source offset |
| dstOff | output | 16 | Current destination offset |
| count | output | 16 | Current element count |
| acc | output | 16 | Accumulator |
| zeroFlag | output | 1 | Equality result of the last compare or scan |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Two things fall in the same cycle when a conditional repeat runs a compare. The zero flag update for an element and the decision to stop or continue both happen in the step cycle, so the stop decision has to use the equality just computed and not the stale flag. The bench provokes this with while-equal and while-unequal runs over strings that first mismatch, or first match, partway through. It judges the final count, both offsets and the flag, each of which is off by one element if the decision uses the old flag. The memory model also varies its stall length per run, which keeps the hold rule on the request under test throughout.

// File: rtl/strx_pkg.sv
package strx_pkg;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_CMP   = 3'd1,
    OP_SCAN  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4
  } strOpE;

  typedef enum logic [1:0] {
    REP_NONE     = 2'd0,
    REP_ALL      = 2'd1,
    REP_WHILE_EQ = 2'd2,
    REP_WHILE_NE = 2'd3
  } repE;

  typedef struct packed {
    logic loadAll;
    logic decCount;
    logic advSrc;
    logic advDst;
    logic capA;
    logic capB;
    logic loadAcc;
    logic updFlag;
    logic useAccCmp;
    logic addrDst;
    logic wdataAcc;
  } ctrlStrobeT;

endpackage

// File: rtl/strx_ctrl.sv
module strx_ctrl
  import strx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opSel,
  input  logic [1:0] repSel,
  input  logic       memReady,
  input  logic       countZero,
  input  logic       cmpEq,
  output ctrlStrobeT stb,
  output logic       memReq,
  output logic       memWrite,
  output logic       busy,
  output logic       done
);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_RDA, S_RDB, S_WR, S_STEP, S_DONE
  } stateE;

  stateE state, nextState;
  strOpE opR;
  repE   repR;

  function automatic strOpE decodeOp(input logic [2:0] code);
    case (code)
      3'd1:    return OP_CMP;
      3'd2:    return OP_SCAN;
      3'd3:    return OP_LOAD;
      3'd4:    return OP_STORE;
      default: return OP_MOVE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opR   <= OP_MOVE;
      repR  <= REP_NONE;
    end else begin
      state <= nextState;
      if (state == S_IDLE && start) begin
        opR  <= decodeOp(opSel);
        repR <= repE'(repSel);
      end
    end
  end

  logic usesSrc, usesDst, isCmp, stopEarly;
  assign usesSrc = (opR == OP_MOVE) || (opR == OP_CMP) || (opR == OP_LOAD);
  assign usesDst = (opR != OP_LOAD);
  assign isCmp   = (opR == OP_CMP) || (opR == OP_SCAN);
  assign stopEarly = isCmp && (((repR == REP_WHILE_EQ) && !cmpEq) ||
                               ((repR == REP_WHILE_NE) && cmpEq));

  always_comb begin
    stb       = '0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          stb.loadAll = 1'b1;
          nextState   = S_CHECK;
        end
      end
      S_CHECK: begin
        if (repR != REP_NONE && countZero) begin
          nextState = S_DONE;
        end else begin
          stb.decCount = (repR != REP_NONE);
          if (usesSrc)              nextState = S_RDA;
          else if (opR == OP_SCAN)  nextState = S_RDB;
          else                      nextState = S_WR;
        end
      end
      S_RDA: begin
        memReq = 1'b1;
        if (memReady) begin
          stb.capA    = (opR != OP_LOAD);
          stb.loadAcc = (opR == OP_LOAD);
          if (opR == OP_MOVE)     nextState = S_WR;
          else if (opR == OP_CMP) nextState = S_RDB;
          else                    nextState = S_STEP;
        end
      end
      S_RDB: begin
        memReq      = 1'b1;
        stb.addrDst = 1'b1;
        if (memReady) begin
          stb.capB  = 1'b1;
          nextState = S_STEP;
        end
      end
      S_WR: begin
        memReq       = 1'b1;
        memWrite     = 1'b1;
        stb.addrDst  = 1'b1;
        stb.wdataAcc = (opR == OP_STORE);
        if (memReady) nextState = S_STEP;
      end
      S_STEP: begin
        stb.advSrc    = usesSrc;
        stb.advDst    = usesDst;
        stb.updFlag   = isCmp;
        stb.useAccCmp = (opR == OP_SCAN);
        if (repR == REP_NONE || stopEarly) nextState = S_DONE;
        else                                nextState = S_CHECK;
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE) && (state != S_DONE);
  assign done = (state == S_DONE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R8
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(busy && done)); // R8
  AST_WRITE_OPS: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite) |-> (opR == OP_MOVE || opR == OP_STORE)); // R7
  AST_FLAG_OPS: assert property (@(posedge clk) disable iff (!rstN)
    stb.updFlag |-> isCmp); // R6

endmodule

// File: rtl/strx_dpath.sv
module strx_dpath
  import strx_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int LANES     = 2,
  parameter int SEG_SHIFT = 4,
  localparam int DATA_W   = BYTE_W * LANES,
  localparam int ADDR_W   = OFF_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        stb,
  input  logic              wideIn,
  input  logic              dirIn,
  input  logic [OFF_W-1:0]  srcSegIn,
  input  logic [OFF_W-1:0]  dstSegIn,
  input  logic [OFF_W-1:0]  srcOffIn,
  input  logic [OFF_W-1:0]  dstOffIn,
  input  logic [OFF_W-1:0]  countIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWide,
  output logic [OFF_W-1:0]  srcOff,
  output logic [OFF_W-1:0]  dstOff,
  output logic [OFF_W-1:0]  count,
  output logic [DATA_W-1:0] acc,
  output logic              zeroFlag,
  output logic              countZero,
  output logic              cmpEq
);

  logic [OFF_W-1:0]  srcSegR, dstSegR, srcOffR, dstOffR, countR;
  logic [DATA_W-1:0] accR, tmpA, tmpB;
  logic              wideR, dirR, zfR;

  logic [OFF_W-1:0] stepAmt, srcNext, dstNext;
  assign stepAmt = wideR ? OFF_W'(LANES) : OFF_W'(1);
  assign srcNext = dirR ? (srcOffR - stepAmt) : (srcOffR + stepAmt);
  assign dstNext = dirR ? (dstOffR - stepAmt) : (dstOffR + stepAmt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSegR <= '0; dstSegR <= '0; srcOffR <= '0; dstOffR <= '0;
      countR  <= '0; accR    <= '0; tmpA    <= '0; tmpB    <= '0;
      wideR   <= 1'b0; dirR  <= 1'b0; zfR <= 1'b0;
    end else begin
      if (stb.loadAll) begin
        srcSegR <= srcSegIn; dstSegR <= dstSegIn;
        srcOffR <= srcOffIn; dstOffR <= dstOffIn;
        countR  <= countIn;  accR    <= accIn;
        wideR   <= wideIn;   dirR    <= dirIn;
      end
      if (stb.decCount) countR  <= countR - 1'b1;
      if (stb.advSrc)   srcOffR <= srcNext;
      if (stb.advDst)   dstOffR <= dstNext;
      if (stb.capA)     tmpA    <= memRdata;
      if (stb.capB)     tmpB    <= memRdata;
      if (stb.loadAcc) begin
        if (wideR) accR <= memRdata;
        else       accR[BYTE_W-1:0] <= memRdata[BYTE_W-1:0];
      end
      if (stb.updFlag)  zfR <= cmpEq;
    end
  end

  logic [OFF_W-1:0]  segSel, offSel;
  assign segSel   = stb.addrDst ? dstSegR : srcSegR;
  assign offSel   = stb.addrDst ? dstOffR : srcOffR;
  assign memAddr  = {segSel, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offSel};
  assign memWdata = stb.wdataAcc ? accR : tmpA;
  assign memWide  = wideR;

  logic [DATA_W-1:0] opA;
  logic [LANES-1:0]  laneEq;
  assign opA = stb.useAccCmp ? accR : tmpA;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneEq[l] = (opA[l*BYTE_W +: BYTE_W] == tmpB[l*BYTE_W +: BYTE_W]);
  end
  assign cmpEq = wideR ? (&laneEq) : laneEq[0];

  assign srcOff    = srcOffR;
  assign dstOff    = dstOffR;
  assign count     = countR;
  assign acc       = accR;
  assign zeroFlag  = zfR;
  assign countZero = (countR == '0);

  AST_NO_CX_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    stb.decCount |-> (countR != '0)); // R3

endmodule

// File: rtl/string_xfer_engine.sv
module string_xfer_engine
  import strx_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int LANES     = 2,
  parameter int SEG_SHIFT = 4,
  localparam int DATA_W   = BYTE_W * LANES,
  localparam int ADDR_W   = OFF_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opSel,
  input  logic [1:0]        repSel,
  input  logic              wordMode,
  input  logic              dirFlag,
  input  logic [OFF_W-1:0]  srcSegIn,
  input  logic [OFF_W-1:0]  dstSegIn,
  input  logic [OFF_W-1:0]  srcOffIn,
  input  logic [OFF_W-1:0]  dstOffIn,
  input  logic [OFF_W-1:0]  countIn,
  input  logic [DATA_W-1:0] accIn,
  output logic              memReq,
  output logic              memWrite,
  output logic              memWide,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic [OFF_W-1:0]  srcOff,
  output logic [OFF_W-1:0]  dstOff,
  output logic [OFF_W-1:0]  count,
  output logic [DATA_W-1:0] acc,
  output logic              zeroFlag,
  output logic              busy,
  output logic              done
);

  ctrlStrobeT stb;
  logic       countZero, cmpEq;

  strx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .repSel(repSel),
    .memReady(memReady), .countZero(countZero), .cmpEq(cmpEq),
    .stb(stb), .memReq(memReq), .memWrite(memWrite), .busy(busy), .done(done)
  );

  strx_dpath #(
    .OFF_W(OFF_W), .BYTE_W(BYTE_W), .LANES(LANES), .SEG_SHIFT(SEG_SHIFT)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wideIn(wordMode), .dirIn(dirFlag),
    .srcSegIn(srcSegIn), .dstSegIn(dstSegIn), .srcOffIn(srcOffIn),
    .dstOffIn(dstOffIn), .countIn(countIn), .accIn(accIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWide(memWide),
    .srcOff(srcOff), .dstOff(dstOff), .count(count), .acc(acc),
    .zeroFlag(zeroFlag), .countZero(countZero), .cmpEq(cmpEq)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWrite) && $stable(memWdata))); // R9

endmodule

// File: tb/string_xfer_engine_tb.sv
module string_xfer_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] DS = 16'h0010;  // base 0x00100
  localparam logic [15:0] ES = 16'h0030;  // base 0x00300

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = '0;
  logic [1:0]  repSel = '0;
  logic        wordMode = 1'b0, dirFlag = 1'b0;
  logic [15:0] srcSegIn = DS, dstSegIn = ES, srcOffIn = '0, dstOffIn = '0, countIn = '0, accIn = '0;
  logic        memReq, memWrite, memWide, busy, done, zeroFlag;
  logic [19:0] memAddr;
  logic [15:0] memWdata, srcOff, dstOff, count, acc;
  logic [15:0] memRdata = '0;
  logic        memReady = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  string_xfer_engine dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .repSel(repSel),
    .wordMode(wordMode), .dirFlag(dirFlag), .srcSegIn(srcSegIn), .dstSegIn(dstSegIn),
    .srcOffIn(srcOffIn), .dstOffIn(dstOffIn), .countIn(countIn), .accIn(accIn),
    .memReq(memReq), .memWrite(memWrite), .memWide(memWide), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .srcOff(srcOff), .dstOff(dstOff), .count(count), .acc(acc),
    .zeroFlag(zeroFlag), .busy(busy), .done(done)
  );

  int nChecks = 0, nErrors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: 4 KB window indexed by the low 12 address bits
  logic [7:0]  mem [0:4095];
  int          stallN = 0, waitCnt = 0, xferCnt = 0, stabErr = 0;
  bit          pendPrev = 1'b0;
  logic [19:0] prevAddr = '0;
  logic        prevWr = 1'b0;
  logic [15:0] prevWd = '0;

  task automatic initMem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i) ^ 8'hA5;
    for (int i = 0; i < 16; i++) begin
      mem[12'h100 + i] = 8'h41 + 8'(i);
      mem[12'h300 + i] = (i < 5) ? 8'h41 + 8'(i) : 8'h61 + 8'(i);
    end
    mem[12'h308] = 8'h49;
  endtask

  always @(negedge clk) begin
    if (pendPrev && (!memReq || memAddr != prevAddr || memWrite != prevWr ||
                     (memWrite && memWdata != prevWd))) stabErr++;
    pendPrev = 1'b0;
    if (memReady) memReady = 1'b0;
    else if (memReq) begin
      if (waitCnt < stallN) begin
        waitCnt++;
        pendPrev = 1'b1; prevAddr = memAddr; prevWr = memWrite; prevWd = memWdata;
      end else begin
        waitCnt  = 0;
        memReady = 1'b1;
        xferCnt++;
        if (memWrite) begin
          mem[memAddr[11:0]] = memWdata[7:0];
          if (memWide) mem[12'(memAddr + 20'd1)] = memWdata[15:8];
        end else begin
          memRdata = memWide ? {mem[12'(memAddr + 20'd1)], mem[memAddr[11:0]]}
                             : {8'h00, mem[memAddr[11:0]]};
        end
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runOp(input logic [2:0] op, input logic [1:0] rep, input logic w, input logic d,
                       input logic [15:0] si, input logic [15:0] di, input logic [15:0] cx,
                       input logic [15:0] a, input int stall, input bit poke);
    int cyc;
    @(negedge clk);
    opSel = op; repSel = rep; wordMode = w; dirFlag = d;
    srcOffIn = si; dstOffIn = di; countIn = cx; accIn = a;
    stallN = stall; xferCnt = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", busy, 1);
    cyc = 0;
    while (!done && cyc < 5000) begin
      if (!busy) chk("R8 busy held until end", busy, 1);
      if (poke && cyc == 2) begin
        start = 1'b1; opSel = 3'd4; countIn = 16'h0009; accIn = 16'hDEAD;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (!done) chk("R8 run terminates", 0, 1);
    chk("R8 busy low with done", busy, 0);
    @(negedge clk);
    chk("R8 done lasts one cycle", done, 0);
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  rep;
    logic        wide;
    logic        dir;
    logic [15:0] si, di, cx, acc, eSi, eDi, eCx, eAcc;
    logic        eZf;
    logic [7:0]  eXf;
    logic [11:0] chkIdx;
    logic [7:0]  chkVal;
  } vecT;

  localparam int NVEC = 12;
  localparam vecT VEC [NVEC] = '{
    // copy x3 upward (R3 R7)
    '{3'd0,2'd1,1'b0,1'b0,16'h0000,16'h0020,16'h0003,16'h1234,16'h0003,16'h0023,16'h0000,16'h1234,1'b0,8'd6, 12'h322,8'h43},
    // compare while equal, mismatch at element 5 (R4)
    '{3'd1,2'd2,1'b0,1'b0,16'h0000,16'h0000,16'h0009,16'h0000,16'h0006,16'h0006,16'h0003,16'h0000,1'b0,8'd12,12'h305,8'h66},
    // compare while equal, runs out of count (R4 R3)
    '{3'd1,2'd2,1'b0,1'b0,16'h0000,16'h0000,16'h0003,16'h0000,16'h0003,16'h0003,16'h0000,16'h0000,1'b1,8'd6, 12'h300,8'h41},
    // compare while unequal, match at element 8 (R4)
    '{3'd1,2'd3,1'b0,1'b0,16'h0005,16'h0005,16'h0008,16'h0000,16'h0009,16'h0009,16'h0004,16'h0000,1'b1,8'd8, 12'h308,8'h49},
    // scan while unequal for 0x44 (R4 R7)
    '{3'd2,2'd3,1'b0,1'b0,16'h0777,16'h0000,16'h000A,16'h0044,16'h0777,16'h0004,16'h0006,16'h0044,1'b1,8'd4, 12'h303,8'h44},
    // single word load, downward (R5 R2 R7 R1)
    '{3'd3,2'd0,1'b1,1'b1,16'h0004,16'h0099,16'h0007,16'hFFFF,16'h0002,16'h0099,16'h0007,16'h4645,1'b0,8'd1, 12'h104,8'h45},
    // byte store x2 downward (R2 R7)
    '{3'd4,2'd1,1'b0,1'b1,16'h0123,16'h0042,16'h0002,16'hAB5A,16'h0123,16'h0040,16'h0000,16'hAB5A,1'b0,8'd2, 12'h341,8'h5A},
    // word copy with source offset wrap (R1 R2)
    '{3'd0,2'd1,1'b1,1'b0,16'hFFFF,16'h0050,16'h0002,16'h0000,16'h0003,16'h0054,16'h0000,16'h0000,1'b0,8'd4, 12'h353,8'h43},
    // copy with zero count: nothing (R3)
    '{3'd0,2'd1,1'b0,1'b0,16'h0000,16'h0020,16'h0000,16'h0000,16'h0000,16'h0020,16'h0000,16'h0000,1'b0,8'd0, 12'h320,8'h85},
    // conditional compare with zero count: nothing (R3 R4)
    '{3'd1,2'd2,1'b0,1'b0,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,1'b0,8'd0, 12'h300,8'h41},
    // single word compare, equal (R5 R6)
    '{3'd1,2'd0,1'b1,1'b0,16'h0000,16'h0000,16'h0005,16'h0000,16'h0002,16'h0002,16'h0005,16'h0000,1'b1,8'd2, 12'h300,8'h41},
    // copy under while-equal code acts unconditional (R4)
    '{3'd0,2'd2,1'b0,1'b0,16'h0000,16'h0060,16'h0002,16'h0000,16'h0002,16'h0062,16'h0000,16'h0000,1'b0,8'd4, 12'h361,8'h42}
  };

  initial begin
    initMem();
    doReset();
    chk("R8 reset busy", busy, 0);
    chk("R8 reset done", done, 0);
    chk("R9 reset memReq", memReq, 0);
    chk("R6 reset zeroFlag", zeroFlag, 0);

    for (int i = 0; i < NVEC; i++) begin
      string tg;
      initMem();
      doReset();
      runOp(VEC[i].op, VEC[i].rep, VEC[i].wide, VEC[i].dir, VEC[i].si, VEC[i].di,
            VEC[i].cx, VEC[i].acc, i % 3, 1'b0);
      tg = $sformatf("vector %0d [R1 R2 R3 R4 R5 R7]", i);
      chk({tg, " srcOff"}, srcOff, VEC[i].eSi);
      chk({tg, " dstOff"}, dstOff, VEC[i].eDi);
      chk({tg, " count"}, count, VEC[i].eCx);
      chk({tg, " acc"}, acc, VEC[i].eAcc);
      chk($sformatf("vector %0d R6 zeroFlag", i), zeroFlag, VEC[i].eZf);
      chk({tg, " accesses"}, xferCnt, VEC[i].eXf);
      chk({tg, " memory byte"}, mem[VEC[i].chkIdx], VEC[i].chkVal);
    end

    // R8: a start pulse during a run is ignored
    initMem();
    doReset();
    runOp(3'd0, 2'd1, 1'b0, 1'b0, 16'h0000, 16'h0020, 16'h0003, 16'h1234, 1, 1'b1);
    chk("R8 poke srcOff", srcOff, 16'h0003);
    chk("R8 poke count", count, 16'h0000);
    chk("R8 poke acc", acc, 16'h1234);
    chk("R8 poke memory", mem[12'h321], 8'h42);
    chk("R8 engine idle after run", busy, 0);

    // R6: flag survives copy and load; R7: byte load keeps acc high byte
    initMem();
    doReset();
    runOp(3'd1, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0005, 16'h0000, 0, 1'b0);
    chk("R6 compare sets flag", zeroFlag, 1);
    runOp(3'd0, 2'd1, 1'b0, 1'b0, 16'h0000, 16'h0070, 16'h0001, 16'h0000, 2, 1'b0);
    chk("R6 copy keeps flag", zeroFlag, 1);
    runOp(3'd3, 2'd0, 1'b0, 1'b0, 16'h0002, 16'h0000, 16'h0004, 16'h7700, 0, 1'b0);
    chk("R6 load keeps flag", zeroFlag, 1);
    chk("R7 byte load acc", acc, 16'h7743);
    chk("R7 load leaves dstOff", dstOff, 16'h0000);
    runOp(3'd2, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0004, 16'h0099, 0, 1'b0);
    chk("R6 scan mismatch clears flag", zeroFlag, 0);

    chk("R9 request held while stalled", stabErr, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog R8 run did not complete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule